// File: doc/BRIEF.md
# Receive packet claim router

This block sits on the receive side of a packet link and decides, packet by packet, whether the local device owns the traffic. Request commands are matched against a set of address windows. Response commands are matched against the device's own unit identifier. A claimed command raises a write strobe towards the posted, non-posted or response queue, depending on its class. Data beats carry no header of their own, so they follow whatever decision was taken for the command in front of them.

Traffic that nobody claims is not thrown away silently. It goes to an end-of-chain handler, which sorts it by class:
- An orphaned posted request or response sets a sticky error flag.
- An orphaned non-posted request produces a "non-existent address" reply that carries the requester's tag.

The reply is held until the downstream side accepts it. While it waits, the input stream is stalled.

Top module: `rx_claim_router`

## Requirements
- R1: An accepted command of class 2'b00 (posted request) that hits an address window pulses `post_we_o` in the same cycle. A hitting command of class 2'b01 (non-posted request) pulses `np_we_o` in the same cycle.
- R2: Window i hits only when `bar_en_i[i]` is 1 and `(addr ^ base_i) & mask_i` is zero. A mask bit of 1 means that address bit is compared. A disabled window never hits.
- R3: An accepted command of class 2'b10 (response) whose `pkt_unit_i` equals `unit_id_i` pulses `rsp_we_o`.
- R4: A data beat (`pkt_is_data_i`=1) pulses the same queue strobe as the most recent accepted command when that command was claimed. Otherwise the data beat is unclaimed.
- R5: Each accepted packet raises exactly one of `post_we_o`, `np_we_o`, `rsp_we_o`, `unclaimed_o`. A command of class 2'b11 is always unclaimed and logs nothing.
- R6: An unclaimed posted command sets `err_post_o`, and an unclaimed response command sets `err_rsp_o`, from the next cycle on. Data beats and non-posted commands set neither flag.
- R7: The error flags are sticky. `err_clr_i[0]` clears `err_post_o` and `err_clr_i[1]` clears `err_rsp_o`. A new error in the same cycle wins over the clear.
- R8: An unclaimed non-posted command raises `nxa_vld_o` from the next cycle, with `nxa_tag_o` equal to its `pkt_tag_i`. Valid and tag then hold until a cycle with `nxa_rdy_i` high.
- R9: `pkt_rdy_o` is low while a reply is pending and `nxa_rdy_i` is low. A packet offered without `pkt_rdy_o` produces no strobe.
- R10: After reset, both error flags are clear, no reply is pending, `pkt_rdy_o` is high, and a data beat arriving before any command is unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_vld_i | input | 1 | Packet offered |
| pkt_rdy_o | output | 1 | Packet can be accepted |
| pkt_is_data_i | input | 1 | 1 = data beat, 0 = command |
| pkt_cls_i | input | 2 | Command class: 00 posted, 01 non-posted, 10 response, 11 reserved |
| pkt_addr_i | input | ADDR_W | Request address |
| pkt_unit_i | input | UNIT_W | Response unit identifier |
| pkt_tag_i | input | TAG_W | Source tag of the request |
| pkt_data_i | input | DATA_W | Packet payload |
| bar_base_i | input | NUM_BAR*ADDR_W | Window base addresses |
| bar_mask_i | input | NUM_BAR*ADDR_W | Window compare masks |
| bar_en_i | input | NUM_BAR | Window enables |
| unit_id_i | input | UNIT_W | Own unit identifier |
| post_we_o | output | 1 | Posted queue write |
| np_we_o | output | 1 | Non-posted queue write |
| rsp_we_o | output | 1 | Response queue write |
| q_data_o | output | DATA_W | Payload to the queues |
| unclaimed_o | output | 1 | Packet passed to the end-of-chain handler |
| err_post_o | output | 1 | Sticky unclaimed-posted error |
| err_rsp_o | output | 1 | Sticky unclaimed-response error |
| err_clr_i | input | 2 | Write-one-to-clear for the error flags |
| nxa_vld_o | output | 1 | Non-existent-address reply valid |
| nxa_rdy_i | input | 1 | Reply accepted downstream |
| nxa_tag_o | output | TAG_W | Tag of the reply |
| nxa_unit_o | output | UNIT_W | Unit identifier of the reply |

## Verification
The hardest situation to reach is a data beat that trails an unclaimed non-posted request. That beat arrives just as the error reply is waiting on a stalled downstream port, so the stream halts in the middle of a packet.

The stimulus holds `nxa_rdy_i` low after such a request and keeps offering the data beat for several cycles. It checks that the beat is not taken and that the reply stays stable. Only then is the reply released, and the beat must finally come out as unclaimed rather than as a queue write.

// File: rtl/rx_claim_pkg.sv
package rx_claim_pkg;
  typedef enum logic [1:0] {
    CLS_POST = 2'b00,
    CLS_NP   = 2'b01,
    CLS_RSP  = 2'b10,
    CLS_RSVD = 2'b11
  } pkt_cls_e;

  typedef struct packed {
    logic     claimed;
    pkt_cls_e cls;
  } route_t;
endpackage

// File: rtl/rx_bar_match.sv
module rx_bar_match #(
  parameter int NUM_BAR = 2,
  parameter int ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_BAR*ADDR_W-1:0] base_i,
  input  logic [NUM_BAR*ADDR_W-1:0] mask_i,
  input  logic [NUM_BAR-1:0]        en_i,
  output logic                      hit_o
);
  logic [NUM_BAR-1:0] hit_vec;

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_win
    logic [ADDR_W-1:0] base_w, mask_w;
    assign base_w     = base_i[i*ADDR_W +: ADDR_W];
    assign mask_w     = mask_i[i*ADDR_W +: ADDR_W];
    assign hit_vec[i] = en_i[i] && (((addr_i ^ base_w) & mask_w) == '0);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/rx_claim_dec.sv
module rx_claim_dec
  import rx_claim_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     acc_i,
  input  logic     is_data_i,
  input  pkt_cls_e cls_i,
  input  logic     bar_hit_i,
  input  logic     unit_hit_i,
  output route_t   route_o
);
  route_t cur_q, cmd_route;

  always_comb begin
    cmd_route.cls = cls_i;
    unique case (cls_i)
      CLS_POST, CLS_NP: cmd_route.claimed = bar_hit_i;
      CLS_RSP:          cmd_route.claimed = unit_hit_i;
      default:          cmd_route.claimed = 1'b0;
    endcase
  end

  // data beats inherit the last command's decision
  assign route_o = is_data_i ? cur_q : cmd_route;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cur_q <= '{claimed: 1'b0, cls: CLS_RSVD};
    else if (acc_i && !is_data_i) cur_q <= cmd_route;
  end
endmodule

// File: rtl/rx_eoc_handler.sv
module rx_eoc_handler
  import rx_claim_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             is_data_i,
  input  pkt_cls_e         cls_i,
  input  logic             claimed_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       err_clr_i,
  input  logic             nxa_rdy_i,
  output logic             err_post_o,
  output logic             err_rsp_o,
  output logic             nxa_vld_o,
  output logic [TAG_W-1:0] nxa_tag_o,
  output logic             busy_o
);
  logic orphan_cmd, set_post, set_rsp, set_nxa;

  assign orphan_cmd = acc_i && !is_data_i && !claimed_i;
  assign set_post   = orphan_cmd && (cls_i == CLS_POST);
  assign set_rsp    = orphan_cmd && (cls_i == CLS_RSP);
  assign set_nxa    = orphan_cmd && (cls_i == CLS_NP);
  assign busy_o     = nxa_vld_o && !nxa_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_post_o <= 1'b0;
      err_rsp_o  <= 1'b0;
    end else begin
      err_post_o <= (err_post_o && !err_clr_i[0]) || set_post;
      err_rsp_o  <= (err_rsp_o  && !err_clr_i[1]) || set_rsp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxa_vld_o <= 1'b0;
      nxa_tag_o <= '0;
    end else if (set_nxa) begin
      nxa_vld_o <= 1'b1;
      nxa_tag_o <= tag_i;
    end else if (nxa_rdy_i) begin
      nxa_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_claim_router.sv
module rx_claim_router
  import rx_claim_pkg::*;
#(
  parameter int NUM_BAR = 2,
  parameter int ADDR_W  = 32,
  parameter int UNIT_W  = 5,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pkt_vld_i,
  output logic                      pkt_rdy_o,
  input  logic                      pkt_is_data_i,
  input  logic [1:0]                pkt_cls_i,
  input  logic [ADDR_W-1:0]         pkt_addr_i,
  input  logic [UNIT_W-1:0]         pkt_unit_i,
  input  logic [TAG_W-1:0]          pkt_tag_i,
  input  logic [DATA_W-1:0]         pkt_data_i,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_base_i,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_mask_i,
  input  logic [NUM_BAR-1:0]        bar_en_i,
  input  logic [UNIT_W-1:0]         unit_id_i,
  output logic                      post_we_o,
  output logic                      np_we_o,
  output logic                      rsp_we_o,
  output logic [DATA_W-1:0]         q_data_o,
  output logic                      unclaimed_o,
  output logic                      err_post_o,
  output logic                      err_rsp_o,
  input  logic [1:0]                err_clr_i,
  output logic                      nxa_vld_o,
  input  logic                      nxa_rdy_i,
  output logic [TAG_W-1:0]          nxa_tag_o,
  output logic [UNIT_W-1:0]         nxa_unit_o
);
  pkt_cls_e cls;
  route_t   route;
  logic     acc, bar_hit, unit_hit, busy;

  assign cls       = pkt_cls_e'(pkt_cls_i);
  assign pkt_rdy_o = !busy;
  assign acc       = pkt_vld_i && pkt_rdy_o;
  assign unit_hit  = (pkt_unit_i == unit_id_i);

  rx_bar_match #(.NUM_BAR(NUM_BAR), .ADDR_W(ADDR_W)) u_bar (
    .addr_i(pkt_addr_i), .base_i(bar_base_i), .mask_i(bar_mask_i),
    .en_i(bar_en_i), .hit_o(bar_hit)
  );

  rx_claim_dec u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .is_data_i(pkt_is_data_i),
    .cls_i(cls), .bar_hit_i(bar_hit), .unit_hit_i(unit_hit), .route_o(route)
  );

  rx_eoc_handler #(.TAG_W(TAG_W)) u_eoc (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .is_data_i(pkt_is_data_i),
    .cls_i(cls), .claimed_i(route.claimed), .tag_i(pkt_tag_i),
    .err_clr_i(err_clr_i), .nxa_rdy_i(nxa_rdy_i),
    .err_post_o(err_post_o), .err_rsp_o(err_rsp_o),
    .nxa_vld_o(nxa_vld_o), .nxa_tag_o(nxa_tag_o), .busy_o(busy)
  );

  assign post_we_o   = acc && route.claimed && (route.cls == CLS_POST);
  assign np_we_o     = acc && route.claimed && (route.cls == CLS_NP);
  assign rsp_we_o    = acc && route.claimed && (route.cls == CLS_RSP);
  assign unclaimed_o = acc && !route.claimed;
  assign q_data_o    = pkt_data_i;
  assign nxa_unit_o  = unit_id_i;
endmodule

// File: rtl/rx_claim_router_chk.sv
module rx_claim_router_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_vld_i,
  input logic             pkt_rdy_o,
  input logic             pkt_is_data_i,
  input logic [1:0]       pkt_cls_i,
  input logic             post_we_o,
  input logic             np_we_o,
  input logic             rsp_we_o,
  input logic             unclaimed_o,
  input logic             err_post_o,
  input logic [1:0]       err_clr_i,
  input logic             nxa_vld_o,
  input logic             nxa_rdy_i,
  input logic [TAG_W-1:0] nxa_tag_o
);
  logic accepted;
  assign accepted = pkt_vld_i && pkt_rdy_o;

  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted |-> $countones({post_we_o, np_we_o, rsp_we_o, unclaimed_o}) == 1);

  p_no_accept_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accepted |-> !(post_we_o || np_we_o || rsp_we_o || unclaimed_o));

  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxa_vld_o && !nxa_rdy_i) |-> !pkt_rdy_o);

  p_nxa_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxa_vld_o && !nxa_rdy_i) |=> (nxa_vld_o && $stable(nxa_tag_o)));

  p_nxa_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepted && !pkt_is_data_i && pkt_cls_i == 2'b01 && unclaimed_o) |=> nxa_vld_o);

  p_err_post_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accepted && !pkt_is_data_i && pkt_cls_i == 2'b00 && unclaimed_o) |=> err_post_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_post_o && !err_clr_i[0]) |=> err_post_o);
endmodule

bind rx_claim_router rx_claim_router_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_vld_i(pkt_vld_i), .pkt_rdy_o(pkt_rdy_o),
  .pkt_is_data_i(pkt_is_data_i), .pkt_cls_i(pkt_cls_i), .post_we_o(post_we_o),
  .np_we_o(np_we_o), .rsp_we_o(rsp_we_o), .unclaimed_o(unclaimed_o),
  .err_post_o(err_post_o), .err_clr_i(err_clr_i), .nxa_vld_o(nxa_vld_o),
  .nxa_rdy_i(nxa_rdy_i), .nxa_tag_o(nxa_tag_o)
);

// File: tb/tb_rx_claim_router.sv
`timescale 1ns/1ps
module tb_rx_claim_router;
  localparam int NB = 2, AW = 32, UW = 5, TW = 5, DW = 32;
  localparam logic [3:0] E_POST = 4'b1000, E_NP = 4'b0100, E_RSP = 4'b0010, E_UNC = 4'b0001;

  logic clk = 0, rst_n = 0;
  logic pkt_vld = 0, pkt_rdy, pkt_is_data = 0;
  logic [1:0] pkt_cls = 0;
  logic [AW-1:0] pkt_addr = 0;
  logic [UW-1:0] pkt_unit = 0;
  logic [TW-1:0] pkt_tag = 0;
  logic [DW-1:0] pkt_data = 0;
  logic [NB*AW-1:0] bar_base, bar_mask;
  logic [NB-1:0] bar_en;
  logic [UW-1:0] unit_id = 5'd5;
  logic post_we, np_we, rsp_we, unclaimed, err_post, err_rsp, nxa_vld;
  logic [1:0] err_clr = 0;
  logic nxa_rdy = 0;
  logic [TW-1:0] nxa_tag;
  logic [UW-1:0] nxa_unit;
  logic [DW-1:0] q_data;

  int checks = 0, fails = 0;
  logic [3:0] exp_q[$];
  string req_q[$];
  logic mdl_claimed = 0;
  logic [3:0] mdl_code = E_UNC;

  always #5 clk = ~clk;

  rx_claim_router #(.NUM_BAR(NB), .ADDR_W(AW), .UNIT_W(UW), .TAG_W(TW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pkt_vld_i(pkt_vld), .pkt_rdy_o(pkt_rdy),
    .pkt_is_data_i(pkt_is_data), .pkt_cls_i(pkt_cls), .pkt_addr_i(pkt_addr),
    .pkt_unit_i(pkt_unit), .pkt_tag_i(pkt_tag), .pkt_data_i(pkt_data),
    .bar_base_i(bar_base), .bar_mask_i(bar_mask), .bar_en_i(bar_en), .unit_id_i(unit_id),
    .post_we_o(post_we), .np_we_o(np_we), .rsp_we_o(rsp_we), .q_data_o(q_data),
    .unclaimed_o(unclaimed), .err_post_o(err_post), .err_rsp_o(err_rsp),
    .err_clr_i(err_clr), .nxa_vld_o(nxa_vld), .nxa_rdy_i(nxa_rdy),
    .nxa_tag_o(nxa_tag), .nxa_unit_o(nxa_unit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // independent model of window and unit matching (R2, R3)
  function automatic logic win_hit(logic [AW-1:0] a);
    for (int i = 0; i < NB; i++)
      if (bar_en[i] && (((a ^ bar_base[i*AW +: AW]) & bar_mask[i*AW +: AW]) == 0)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] predict(logic d, logic [1:0] c, logic [AW-1:0] a, logic [UW-1:0] u);
    logic [3:0] code;
    if (d) return mdl_claimed ? mdl_code : E_UNC;
    case (c)
      2'b00: code = win_hit(a) ? E_POST : E_UNC;
      2'b01: code = win_hit(a) ? E_NP : E_UNC;
      2'b10: code = (u == unit_id) ? E_RSP : E_UNC;
      default: code = E_UNC;
    endcase
    mdl_claimed = (code != E_UNC);
    mdl_code = code;
    return code;
  endfunction

  task automatic drive(string req, logic d, logic [1:0] c, logic [AW-1:0] a, logic [UW-1:0] u, logic [TW-1:0] t);
    @(posedge clk); #1;
    pkt_is_data = d; pkt_cls = c; pkt_addr = a; pkt_unit = u; pkt_tag = t;
    pkt_data = a ^ 32'h5a5a_0000;
    exp_q.push_back(predict(d, c, a, u));
    req_q.push_back(req);
    pkt_vld = 1;
  endtask

  task automatic send(string req, logic d, logic [1:0] c, logic [AW-1:0] a, logic [UW-1:0] u, logic [TW-1:0] t);
    drive(req, d, c, a, u, t);
    do @(negedge clk); while (!pkt_rdy);
    @(posedge clk); #1;
    pkt_vld = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pkt_vld && pkt_rdy) begin
      if (exp_q.size() == 0) check("R5 unexpected accept", 1, 0);
      else begin
        logic [3:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {post_we, np_we, rsp_we, unclaimed}, e);
        if (e != E_UNC) check({r, " payload"}, q_data, pkt_data);
      end
    end else if (rst_n) begin
      if ({post_we, np_we, rsp_we, unclaimed} != 0) check("R9 strobe without accept", 1, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bar_base = {32'h2000_0000, 32'h1000_0000};
    bar_mask = {32'hFFF0_0000, 32'hFFFF_0000};
    bar_en   = 2'b01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R10 rdy after reset", pkt_rdy, 1);
    check("R10 no reply after reset", nxa_vld, 0);
    check("R10 err flags after reset", {err_post, err_rsp}, 0);
    send("R10 data before any command", 1, 0, 32'h1000_0000, 0, 0);

    send("R1 posted hit", 0, 2'b00, 32'h1000_0040, 0, 1);
    send("R4 data after posted", 1, 0, 0, 0, 0);
    send("R1 np hit at window top", 0, 2'b01, 32'h1000_FFFC, 0, 2);
    send("R4 data after np", 1, 0, 0, 0, 0);
    check("R6 np does not log", {err_post, err_rsp}, 0);

    // R8/R9: unclaimed np just past window, then data stalls
    send("R2 np just outside window", 0, 2'b01, 32'h1001_0000, 0, 5'h13);
    @(negedge clk);
    check("R8 reply valid", nxa_vld, 1);
    check("R8 reply tag", nxa_tag, 5'h13);
    check("R8 reply unit", nxa_unit, 5'd5);
    check("R9 rdy low while pending", pkt_rdy, 0);
    drive("R4 data after unclaimed np", 1, 0, 32'h1000_0000, 0, 0);
    repeat (3) begin
      @(negedge clk);
      check("R9 still stalled", pkt_rdy, 0);
      check("R8 reply held", {nxa_vld, nxa_tag}, {1'b1, 5'h13});
    end
    @(posedge clk); #1 nxa_rdy = 1;
    @(negedge clk);
    check("R9 rdy with downstream ready", pkt_rdy, 1);
    @(posedge clk); #1 pkt_vld = 0; nxa_rdy = 0;
    @(negedge clk);
    check("R8 reply drained", nxa_vld, 0);
    check("R6 data beat does not log", {err_post, err_rsp}, 0);

    send("R2 disabled window", 0, 2'b00, 32'h2000_0000, 0, 3);
    @(negedge clk);
    check("R6 posted error set", err_post, 1);
    bar_en = 2'b11;
    send("R2 enabled second window", 0, 2'b00, 32'h200F_FFF0, 0, 4);

    send("R3 response own unit", 0, 2'b10, 0, 5'd5, 0);
    send("R4 data after response", 1, 0, 0, 0, 0);
    check("R6 rsp flag not yet", err_rsp, 0);
    send("R3 response other unit", 0, 2'b10, 0, 5'd6, 0);
    @(negedge clk);
    check("R6 response error set", err_rsp, 1);

    @(posedge clk); #1 err_clr = 2'b01;
    @(posedge clk); #1 err_clr = 2'b00;
    @(negedge clk);
    check("R7 clear posted only", {err_post, err_rsp}, 2'b01);

    send("R5 reserved class", 0, 2'b11, 32'h1000_0000, 5'd5, 0);
    @(negedge clk);
    check("R5 reserved logs nothing new", {err_post, err_rsp, nxa_vld}, 3'b010);

    @(posedge clk); #1 err_clr = 2'b10;
    @(posedge clk); #1 err_clr = 2'b00;
    @(negedge clk);
    check("R7 clear response", err_rsp, 0);

    // R7: new error in same cycle as clear wins
    send("R7 posted miss", 0, 2'b00, 32'h3000_0000, 0, 0);
    drive("R7 posted miss with clear", 0, 2'b00, 32'h3000_0004, 0, 0);
    err_clr = 2'b01;
    @(posedge clk); #1 pkt_vld = 0; err_clr = 2'b00;
    @(negedge clk);
    check("R7 set wins over clear", err_post, 1);

    repeat (2) @(posedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule